// File: doc/BRIEF.md
# Receive FIFO Identifier Filter Matcher

This block decides whether a received CAN frame header is accepted by a receive FIFO, and which filter accepted it. It holds no table of its own. A packed 8-element filter table and a packed 8-element mask table come in as inputs. Each element is 32 bits wide, and each element has its own mask word at the same position. A format selector sets how every element is read: as one extended-identifier filter, as two standard-identifier filters, or as four 8-bit identifier-slice filters.

When the frame-valid strobe is high, the header fields are compared with every filter in parallel. The header fields are a 29-bit identifier, the extended flag and the remote-request flag. A mask bit of 1 makes its filter bit count, and a mask bit of 0 makes it a don't-care. This holds for the flag bits as well as for the identifier bits. One clock later the block gives a result strobe, a hit flag and the number of the lowest matching filter. The comparison is purely combinational up to the result register, so a mailbox matcher can evaluate the same frame in the same cycle. A clear hit flag means the FIFO rejects the frame.

Top module: `rxfifo_id_filter`

## Requirements
- R1: With `fmt_sel` = 0 (extended), element e is filter e (0 to 7). Bit 31 holds the remote flag, bit 30 holds the extended flag, bits 28:0 hold the identifier, and bit 29 is never compared. The identifier is compared with `frm_id[28:0]`.
- R2: With `fmt_sel` = 1 (standard), bits 31:16 of element e form filter 2e and bits 15:0 form filter 2e+1. In each half-word, bit 15 holds the remote flag, bit 14 the extended flag and bits 10:0 the identifier, and bits 13:11 are never compared. The identifier is compared with `frm_id[28:18]`.
- R3: With `fmt_sel` = 2 (slice), byte b of element e (b = 0 for bits 31:24 up to b = 3 for bits 7:0) is filter 4e+b. It is compared with `frm_id[28:21]`, and the flags play no part.
- R4: A mask bit of 1 requires the frame bit to equal the filter bit, and a mask bit of 0 ignores that bit. This applies to the remote and extended flag positions as well as to the identifier bits.
- R5: When several filters match, `hit_idx` gives the lowest-numbered one.
- R6: `res_valid` is high for exactly the one cycle after each cycle in which `frm_valid` is high, and is low otherwise.
- R7: In cycles without `frm_valid`, `hit` and `hit_idx` keep their last values, whatever the other inputs do.
- R8: When no filter matches, `hit` is 0 and `hit_idx` is 0. With `fmt_sel` = 3 (reserved), no filter ever matches.
- R9: While `rst_n` is low, `res_valid`, `hit` and `hit_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Table format: 0 extended, 1 standard, 2 slice, 3 reserved |
| filt_tbl | input | 256 | Filter table, element e at bits 32e+31:32e |
| mask_tbl | input | 256 | Mask table, same layout as the filter table |
| frm_valid | input | 1 | Header fields are valid this cycle |
| frm_id | input | 29 | Received identifier (a standard identifier sits in bits 28:18) |
| frm_ide | input | 1 | Received extended-identifier flag |
| frm_rtr | input | 1 | Received remote-request flag |
| res_valid | output | 1 | Result strobe, one cycle after `frm_valid` |
| hit | output | 1 | At least one filter matched |
| hit_idx | output | 5 | Number of the lowest matching filter |

## Verification
Every result is due exactly one clock edge after the `frm_valid` cycle, because the only register between the header and the outputs is the result register. The bench drives its inputs on falling edges. Its behavioural model updates on the rising edge that also loads the design's register. Both sides are then compared on the next falling edge, so the comparison always looks at the result of the frame strobed one cycle earlier. Directed checks send a strobe for one cycle and read the outputs on the following falling edge. The hold checks look again after several idle cycles in which the table and header inputs change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    FMT_EXT   = 2'd0,
    FMT_STD   = 2'd1,
    FMT_SLICE = 2'd2,
    FMT_RSVD  = 2'd3
  } rxf_fmt_e;

  localparam int ELEM_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  // bits that take part in a comparison; the gaps are never compared
  localparam logic [ELEM_W-1:0] EXT_CARE = 32'hDFFF_FFFF;
  localparam logic [HALF_W-1:0] STD_CARE = 16'hC7FF;

  function automatic logic [ELEM_W-1:0] ext_key(input logic [28:0] id,
                                                input logic ide, input logic rtr);
    return {rtr, ide, 1'b0, id};
  endfunction

  function automatic logic [HALF_W-1:0] std_key(input logic [10:0] id,
                                                input logic ide, input logic rtr);
    return {rtr, ide, 3'b000, id};
  endfunction

  function automatic logic eq32(input logic [ELEM_W-1:0] a, input logic [ELEM_W-1:0] b,
                                input logic [ELEM_W-1:0] m);
    return ~|((a ^ b) & m & EXT_CARE);
  endfunction

  function automatic logic eq16(input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b,
                                input logic [HALF_W-1:0] m);
    return ~|((a ^ b) & m & STD_CARE);
  endfunction

  function automatic logic eq8(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b,
                               input logic [BYTE_W-1:0] m);
    return ~|((a ^ b) & m);
  endfunction

endpackage

// File: rtl/rxf_elem_cmp.sv
module rxf_elem_cmp
  import rxf_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int STD_W = 11,
  parameter int SLC_W = 8
) (
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  input  logic [ELEM_W-1:0] filt,
  input  logic [ELEM_W-1:0] mask,
  output logic              ext_hit,
  output logic [1:0]        std_hit,
  output logic [3:0]        slc_hit
);
  localparam int N_HALF = ELEM_W / HALF_W;
  localparam int N_BYTE = ELEM_W / BYTE_W;

  logic [ELEM_W-1:0] ekey;
  logic [HALF_W-1:0] skey;
  logic [SLC_W-1:0]  bkey;

  assign ekey = ext_key(frm_id, frm_ide, frm_rtr);
  assign skey = std_key(frm_id[ID_W-1 -: STD_W], frm_ide, frm_rtr);
  assign bkey = frm_id[ID_W-1 -: SLC_W];

  assign ext_hit = eq32(ekey, filt, mask);

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign std_hit[h] = eq16(skey, filt[ELEM_W-1-HALF_W*h -: HALF_W],
                             mask[ELEM_W-1-HALF_W*h -: HALF_W]);
  end

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    assign slc_hit[b] = eq8(bkey, filt[ELEM_W-1-BYTE_W*b -: BYTE_W],
                            mask[ELEM_W-1-BYTE_W*b -: BYTE_W]);
  end
endmodule

// File: rtl/rxf_lowest.sv
module rxf_lowest #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/rxfifo_id_filter.sv
module rxfifo_id_filter
  import rxf_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ID_W     = 29,
  parameter int STD_W    = 11,
  parameter int SLC_W    = 8,
  localparam int NUM_STD = 2 * NUM_ELEM,
  localparam int NUM_SLC = 4 * NUM_ELEM,
  localparam int IDX_W   = $clog2(NUM_SLC),
  localparam int TBL_W   = NUM_ELEM * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic [TBL_W-1:0] filt_tbl,
  input  logic [TBL_W-1:0] mask_tbl,
  input  logic             frm_valid,
  input  logic [ID_W-1:0]  frm_id,
  input  logic             frm_ide,
  input  logic             frm_rtr,
  output logic             res_valid,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  rxf_fmt_e fmt;
  assign fmt = rxf_fmt_e'(fmt_sel);

  logic [NUM_ELEM-1:0] ext_vec;
  logic [NUM_STD-1:0]  std_vec;
  logic [NUM_SLC-1:0]  slc_vec;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    rxf_elem_cmp #(.ID_W(ID_W), .STD_W(STD_W), .SLC_W(SLC_W)) u_cmp (
      .frm_id  (frm_id),
      .frm_ide (frm_ide),
      .frm_rtr (frm_rtr),
      .filt    (filt_tbl[e*ELEM_W +: ELEM_W]),
      .mask    (mask_tbl[e*ELEM_W +: ELEM_W]),
      .ext_hit (ext_vec[e]),
      .std_hit (std_vec[2*e +: 2]),
      .slc_hit (slc_vec[4*e +: 4])
    );
  end

  // per-filter match vector of the selected format, filter n at bit n
  logic [NUM_SLC-1:0] match_vec;
  always_comb begin
    match_vec = '0;
    unique case (fmt)
      FMT_EXT:   match_vec[NUM_ELEM-1:0] = ext_vec;
      FMT_STD:   match_vec[NUM_STD-1:0]  = std_vec;
      FMT_SLICE: match_vec               = slc_vec;
      default:   match_vec               = '0;
    endcase
  end

  logic             any_match;
  logic [IDX_W-1:0] first_idx;

  rxf_lowest #(.W(NUM_SLC), .IW(IDX_W)) u_pick (
    .req (match_vec),
    .any (any_match),
    .idx (first_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= frm_valid;
      if (frm_valid) begin
        hit     <= any_match;
        hit_idx <= first_idx;
      end
    end
  end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
  parameter int NUM_ELEM = 8,
  parameter int NUM_SLC  = 32,
  parameter int IDX_W    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         fmt_sel,
  input logic               frm_valid,
  input logic [NUM_SLC-1:0] match_vec,
  input logic               res_valid,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx
);
  logic [NUM_SLC-1:0] mv_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mv_d <= '0;
    else if (frm_valid) mv_d <= match_vec;
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid); // R6
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(hit) && $stable(hit_idx)); // R7
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && hit |-> mv_d[hit_idx] &&
      ((mv_d & ((NUM_SLC'(1) << hit_idx) - NUM_SLC'(1))) == '0)); // R5
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !hit |-> (mv_d == '0) && (hit_idx == '0)); // R8
  AST_RSVD_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && fmt_sel == 2'd3 |=> !hit); // R8
  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && fmt_sel == 2'd0 |=> hit_idx < IDX_W'(NUM_ELEM)); // R1
  AST_STD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && fmt_sel == 2'd1 |=> hit_idx < IDX_W'(2*NUM_ELEM)); // R2
  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!res_valid && !hit && hit_idx == '0); // R9
  end
endmodule

bind rxfifo_id_filter rxf_filter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .frm_valid (frm_valid),
  .match_vec (match_vec),
  .res_valid (res_valid),
  .hit       (hit),
  .hit_idx   (hit_idx)
);

// File: tb/tb_rxfifo_id_filter.sv
module tb_rxfifo_id_filter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = 2'd0;
  logic [255:0] filt_tbl = '0;
  logic [255:0] mask_tbl = '0;
  logic         frm_valid = 1'b0;
  logic [28:0]  frm_id = '0;
  logic         frm_ide = 1'b0;
  logic         frm_rtr = 1'b0;
  logic         res_valid, hit;
  logic [4:0]   hit_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxfifo_id_filter dut (.*);

  // behavioural reference: walk the filters from the highest number down
  function automatic void ref_eval(input logic [1:0] f, input logic [255:0] ft,
                                   input logic [255:0] mt, input logic [28:0] id,
                                   input logic ide, input logic rtr,
                                   output bit h, output int ix);
    int n;
    h = 0; ix = 0;
    n = (f == 0) ? 8 : (f == 1) ? 16 : (f == 2) ? 32 : 0;
    for (int k = n - 1; k >= 0; k--) begin
      bit ok;
      if (f == 0) begin
        logic [31:0] w, m, key;
        w = ft[k*32 +: 32]; m = mt[k*32 +: 32];
        key = {rtr, ide, 1'b0, id};
        ok = (((w ^ key) & m & 32'hDFFF_FFFF) == 0);
      end else if (f == 1) begin
        logic [15:0] w, m, key;
        int sh;
        sh = (k % 2 == 0) ? 16 : 0;
        w = ft[(k/2)*32 + sh +: 16]; m = mt[(k/2)*32 + sh +: 16];
        key = {rtr, ide, 3'b000, id[28:18]};
        ok = (((w ^ key) & m & 16'hC7FF) == 0);
      end else begin
        logic [7:0] w, m;
        int sh;
        sh = (3 - k % 4) * 8;
        w = ft[(k/4)*32 + sh +: 8]; m = mt[(k/4)*32 + sh +: 8];
        ok = (((w ^ id[28:21]) & m) == 0);
      end
      if (ok) begin h = 1; ix = k; end
    end
  endfunction

  bit exp_valid = 0, exp_hit = 0;
  int exp_idx = 0;
  logic [1:0] exp_fmt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 0; exp_hit <= 0; exp_idx <= 0;
    end else begin
      exp_valid <= frm_valid;
      if (frm_valid) begin
        bit h; int ix;
        ref_eval(fmt_sel, filt_tbl, mask_tbl, frm_id, frm_ide, frm_rtr, h, ix);
        exp_hit <= h; exp_idx <= ix; exp_fmt <= fmt_sel;
      end
    end
  end

  // every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      string tag;
      tag = !rst_n ? "R9" : !exp_valid ? "R7" :
            (exp_fmt == 0) ? "R1" : (exp_fmt == 1) ? "R2" : (exp_fmt == 2) ? "R3" : "R8";
      n_cmp++;
      if (res_valid !== exp_valid || hit !== exp_hit || int'(hit_idx) != exp_idx) begin
        n_bad++;
        $display("FAIL %s model: valid/hit/idx actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 tag, res_valid, hit, hit_idx, exp_valid, exp_hit, exp_idx);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] f, input logic [28:0] id, input logic ide,
                      input logic rtr);
    @(negedge clk);
    fmt_sel = f; frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] w);
    for (int e = 0; e < 8; e++) begin
      filt_tbl[e*32 +: 32] = w; mask_tbl[e*32 +: 32] = 32'hFFFF_FFFF;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", res_valid, 0);
    chk("R9 reset hit", hit, 0);
    chk("R9 reset idx", hit_idx, 0);
    rst_n = 1'b1;

    // extended format
    fill(32'hFFFF_FFFF);
    filt_tbl[3*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h1234567};
    send(2'd0, 29'h1234567, 1'b1, 1'b0);
    chk("R1 ext hit", hit, 1); chk("R1 ext idx", hit_idx, 3);
    chk("R6 strobe", res_valid, 1);
    @(negedge clk); chk("R6 strobe ends", res_valid, 0);
    send(2'd0, 29'h1234567, 1'b1, 1'b1);
    chk("R4 rtr full mask", hit, 0); chk("R8 miss idx", hit_idx, 0);
    mask_tbl[3*32 + 31] = 1'b0;
    send(2'd0, 29'h1234567, 1'b1, 1'b1);
    chk("R4 rtr unmasked", hit, 1); chk("R4 rtr unmasked idx", hit_idx, 3);
    send(2'd0, 29'h1234567, 1'b0, 1'b0);
    chk("R4 ide full mask", hit, 0);
    mask_tbl[3*32 + 30] = 1'b0;
    send(2'd0, 29'h1234567, 1'b0, 1'b0);
    chk("R4 ide unmasked", hit, 1);
    mask_tbl[5*32 +: 32] = '0;
    send(2'd0, 29'h1234567, 1'b1, 1'b0);
    chk("R5 lowest of 3,5", hit_idx, 3);
    mask_tbl[1*32 +: 32] = '0;
    send(2'd0, 29'h0000001, 1'b0, 1'b0);
    chk("R5 lowest of 1,5", hit_idx, 1);

    // hold between frames
    frm_id = 29'h0ABCDEF; fmt_sel = 2'd2; fill(32'h0);
    mask_tbl = '0;
    repeat (3) @(negedge clk);
    chk("R7 hold hit", hit, 1); chk("R7 hold idx", hit_idx, 1);

    // standard format
    fill(32'hFFFF_FFFF);
    filt_tbl[2*32 +: 16] = {1'b0, 1'b0, 3'b000, 11'h5A3};
    send(2'd1, {11'h5A3, 18'h15515}, 1'b0, 1'b0);
    chk("R2 std hit", hit, 1); chk("R2 std idx", hit_idx, 5);
    send(2'd1, {11'h5A3, 18'h0}, 1'b1, 1'b0);
    chk("R4 std ide full mask", hit, 0);
    mask_tbl[2*32 + 14] = 1'b0;
    send(2'd1, {11'h5A3, 18'h0}, 1'b1, 1'b0);
    chk("R4 std ide unmasked", hit_idx, 5);
    send(2'd1, {11'h5A2, 18'h0}, 1'b1, 1'b0);
    chk("R2 std id bit differs", hit, 0);

    // slice format
    fill(32'hFFFF_FFFF);
    filt_tbl[6*32 + 16 +: 8] = 8'hA5;
    send(2'd2, {8'hA5, 21'h1F0F0}, 1'b1, 1'b1);
    chk("R3 slice hit", hit, 1); chk("R3 slice idx", hit_idx, 25);
    filt_tbl[2*32 + 16 +: 8] = 8'hA0; mask_tbl[2*32 + 16 +: 8] = 8'hF0;
    send(2'd2, {8'hA5, 21'h0}, 1'b0, 1'b0);
    chk("R4 slice partial mask idx", hit_idx, 9);
    send(2'd3, {8'hA5, 21'h0}, 1'b0, 1'b0);
    chk("R8 reserved rejects", hit, 0); chk("R8 reserved idx", hit_idx, 0);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i % 40 == 0) begin
        for (int w = 0; w < 8; w++) begin
          filt_tbl[w*32 +: 32] = $urandom;
          mask_tbl[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
        end
      end
      fmt_sel = 2'($urandom % 4);
      frm_id = 29'($urandom); frm_ide = 1'($urandom); frm_rtr = 1'($urandom);
      frm_valid = ($urandom % 10) < 7;
    end
    @(negedge clk); frm_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule